// File: doc/BRIEF.md
# Dual-Divider Telephone Tone Synthesizer

This block turns a 6-bit tone command into a stream of signed digital tone samples, using only a 3.58 MHz reference clock as its timebase. The command is presented on a parallel bus and taken in on the falling edge of a strobe. The upper two command bits select the tone family: dual DTMF, single DTMF or musical notes (with standby), modem tones, or musical notes. The lower four bits select the tone or tone pair within that family.

A decode lookup converts the command into the division ratios of two programmable dividers. Each divider advances a 16-step sine sequencer once per division period. When dual DTMF is selected, the two sequencer outputs are added into one 9-bit word. For every other family, only the first divider runs and the second is held idle. Standby stops both dividers and makes the output silent.

Samples leave through a valid/ready stream. After reset, `sample_valid` stays high on every cycle, so a new sample is offered each clock. When the sink holds `sample_ready` low, the word on `sample_data` stays frozen. The tone timebase keeps running while the output is frozen, so any samples produced during the stall are dropped and are never queued. The pitch therefore never depends on back-pressure.

Top module: `tone_gen_top`

## Requirements
- R1: Command decoding works as follows.
  - `tone_cmd[5:4]`=01 selects dual DTMF.
  - 10 selects a modem tone indexed by `[2:0]`. Bit 3 is ignored.
  - 11 selects musical note `[3:0]`.
  - 00 with `[3]`=0 selects a single DTMF tone, with `[2]` choosing the group (0 = low, 1 = high) and `[1:0]` the tone index.
  - 00 with `[3:0]`=1000 is standby.
  - 00 with `[3]`=1 and a nonzero `[2:0]` selects musical note `[2:0]`.
- R2: Every tone step lasts round(3579545/(16*f)) clock cycles. The frequency f in Hz is taken from these sets:
  - DTMF low group, index 0..3: 697, 770, 852, 941.
  - DTMF high group, index 0..3: 1209, 1336, 1477, 1633.
  - Modem, index 0..7: 1070, 1270, 2025, 2225, 1200, 2200, 980, 1180.
  - Musical note n: 440*2^(n/12).
- R3: In dual DTMF, `[3:2]` picks the low-group tone and `[1:0]` picks the high-group tone. The output is the sum of both sine values.
- R4: In single DTMF, modem and musical modes, the output is one sine value and its magnitude never exceeds 127.
- R5: Each sine runs through 16 steps with the values round(127*sin(2*pi*s/16)), for s = 0..15, starting at s = 0. Each step lasts exactly the divider ratio in cycles.
- R6: The command is loaded on the third rising clock edge after the strobe falls, and both dividers restart at that edge. The word on `sample_data` after the fourth edge is the step-0 value. This also holds when the same command is loaded again.
- R7: A command bus change or a strobe rising edge without a subsequent falling edge has no effect, and the loaded tone continues.
- R8: In reset, `sample_valid` and `sample_data` are 0. Reset selects standby. In standby, the output word is 0.
- R9: `sample_valid` goes high one cycle after reset and stays high. While `sample_ready` is low, `sample_data` holds its value. The tone timebase keeps counting during the stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.58 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_cmd | input | 6 | Tone command, family in [5:4] |
| cmd_strobe | input | 1 | Command strobe, loads on falling edge |
| sample_valid | output | 1 | Output sample available |
| sample_ready | input | 1 | Sink accepts sample |
| sample_data | output | 9 | Signed tone sample |

## Verification
Each divider fault shows up at the ports as a step that is too long or too short. Because every pair of neighbouring sine steps differs, a wrong ratio or a missed restart gives a wrong value within one step period, at most 508 cycles after the tone loads. A wrong family decode or a wrong summing lane changes the very first nonzero step. A broken stall hold corrupts the first word after `sample_ready` drops. The stream is compared every cycle against a model that counts from the strobe fall, so a timing error of a single cycle is caught at the first step boundary.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;

  localparam int CMD_W   = 6;
  localparam int RATIO_W = 10;
  localparam int STEP_W  = 4;
  localparam int AMP_W   = 8;
  localparam int SUM_W   = AMP_W + 1;
  localparam int LANES   = 2;

  localparam logic [CMD_W-1:0] STANDBY_CMD = 6'b001000;

  typedef enum logic [1:0] {
    FAM_MIXED = 2'b00,
    FAM_DUAL  = 2'b01,
    FAM_MODEM = 2'b10,
    FAM_MUSIC = 2'b11
  } family_e;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio_lo;
    logic [RATIO_W-1:0] ratio_hi;
    logic               run_lo;
    logic               run_hi;
  } div_cfg_t;

  // Quarter-wave magnitudes; the full 16-step wave is folded from them.
  function automatic logic signed [AMP_W-1:0] sine_at(input logic [STEP_W-1:0] s);
    logic [1:0] q;
    logic [2:0] idx;
    logic [AMP_W-1:0] mag;
    q   = s[1:0];
    idx = s[2] ? (3'd4 - {1'b0, q}) : {1'b0, q};
    case (idx)
      3'd0:    mag = AMP_W'(0);
      3'd1:    mag = AMP_W'(49);
      3'd2:    mag = AMP_W'(90);
      3'd3:    mag = AMP_W'(117);
      default: mag = AMP_W'(127);
    endcase
    return s[3] ? -$signed(mag) : $signed(mag);
  endfunction

  function automatic logic [RATIO_W-1:0] low_ratio(input logic [1:0] i);
    case (i)
      2'd0:    return RATIO_W'(321);
      2'd1:    return RATIO_W'(291);
      2'd2:    return RATIO_W'(263);
      default: return RATIO_W'(238);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] high_ratio(input logic [1:0] i);
    case (i)
      2'd0:    return RATIO_W'(185);
      2'd1:    return RATIO_W'(167);
      2'd2:    return RATIO_W'(151);
      default: return RATIO_W'(137);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] modem_ratio(input logic [2:0] i);
    case (i)
      3'd0:    return RATIO_W'(209);
      3'd1:    return RATIO_W'(176);
      3'd2:    return RATIO_W'(110);
      3'd3:    return RATIO_W'(101);
      3'd4:    return RATIO_W'(186);
      3'd5:    return RATIO_W'(102);
      3'd6:    return RATIO_W'(228);
      default: return RATIO_W'(190);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] note_ratio(input logic [3:0] i);
    case (i)
      4'd0:    return RATIO_W'(508);
      4'd1:    return RATIO_W'(480);
      4'd2:    return RATIO_W'(453);
      4'd3:    return RATIO_W'(428);
      4'd4:    return RATIO_W'(404);
      4'd5:    return RATIO_W'(381);
      4'd6:    return RATIO_W'(360);
      4'd7:    return RATIO_W'(339);
      4'd8:    return RATIO_W'(320);
      4'd9:    return RATIO_W'(302);
      4'd10:   return RATIO_W'(285);
      4'd11:   return RATIO_W'(269);
      4'd12:   return RATIO_W'(254);
      4'd13:   return RATIO_W'(240);
      4'd14:   return RATIO_W'(226);
      default: return RATIO_W'(214);
    endcase
  endfunction

endpackage

// File: rtl/tone_cmd_capture.sv
module tone_cmd_capture
  import tone_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [CMD_W-1:0] cmd_in,
  output logic [CMD_W-1:0] cmd_q,
  output logic             load
);

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   last_r;

  // Synchronizer chain; the oldest stage feeds the edge detector.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_r <= '0;
      last_r <= 1'b0;
    end else begin
      sync_r <= {sync_r[SYNC_STAGES-2:0], strobe};
      last_r <= sync_r[SYNC_STAGES-1];
    end
  end

  assign load = last_r & ~sync_r[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    cmd_q <= STANDBY_CMD;
    else if (load) cmd_q <= cmd_in;
  end

endmodule

// File: rtl/tone_ratio_rom.sv
module tone_ratio_rom
  import tone_gen_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output div_cfg_t         cfg
);

  family_e fam;
  assign fam = family_e'(cmd[5:4]);

  always_comb begin
    cfg.ratio_lo = RATIO_W'(1);
    cfg.ratio_hi = RATIO_W'(1);
    cfg.run_lo   = 1'b0;
    cfg.run_hi   = 1'b0;
    unique case (fam)
      FAM_DUAL: begin
        cfg.ratio_lo = low_ratio(cmd[3:2]);
        cfg.ratio_hi = high_ratio(cmd[1:0]);
        cfg.run_lo   = 1'b1;
        cfg.run_hi   = 1'b1;
      end
      FAM_MODEM: begin
        cfg.ratio_lo = modem_ratio(cmd[2:0]);
        cfg.run_lo   = 1'b1;
      end
      FAM_MUSIC: begin
        cfg.ratio_lo = note_ratio(cmd[3:0]);
        cfg.run_lo   = 1'b1;
      end
      default: begin
        if (!cmd[3]) begin
          cfg.ratio_lo = cmd[2] ? high_ratio(cmd[1:0]) : low_ratio(cmd[1:0]);
          cfg.run_lo   = 1'b1;
        end else if (cmd[2:0] != 3'd0) begin
          cfg.ratio_lo = note_ratio({1'b0, cmd[2:0]});
          cfg.run_lo   = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen
  import tone_gen_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    run,
  input  logic [RATIO_W-1:0]      ratio,
  output logic signed [AMP_W-1:0] sine,
  output logic [RATIO_W-1:0]      cnt,
  output logic [STEP_W-1:0]       step
);

  logic wrap;
  assign wrap = (cnt == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt  <= '0;
      step <= '0;
    end else if (wrap) begin
      cnt  <= '0;
      step <= step + STEP_W'(1);
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assign sine = run ? sine_at(step) : '0;

endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tone_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CMD_W-1:0]        tone_cmd,
  input  logic                    cmd_strobe,
  output logic                    sample_valid,
  input  logic                    sample_ready,
  output logic signed [SUM_W-1:0] sample_data
);

  logic [CMD_W-1:0] cmd_q;
  logic             load;
  div_cfg_t         cfg;

  logic [RATIO_W-1:0]      ratio_v [LANES];
  logic                    run_v   [LANES];
  logic signed [AMP_W-1:0] sine_v  [LANES];
  logic [RATIO_W-1:0]      cnt_v   [LANES];
  logic [STEP_W-1:0]       step_v  [LANES];
  logic signed [SUM_W-1:0] sum;

  tone_cmd_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmd_strobe),
    .cmd_in (tone_cmd),
    .cmd_q  (cmd_q),
    .load   (load)
  );

  tone_ratio_rom u_rom (
    .cmd (cmd_q),
    .cfg (cfg)
  );

  assign ratio_v[0] = cfg.ratio_lo;
  assign ratio_v[1] = cfg.ratio_hi;
  assign run_v[0]   = cfg.run_lo;
  assign run_v[1]   = cfg.run_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tone_phase_gen u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .run     (run_v[g]),
      .ratio   (ratio_v[g]),
      .sine    (sine_v[g]),
      .cnt     (cnt_v[g]),
      .step    (step_v[g])
    );
  end

  // Idle lanes present zero, so the sum is the single tone or silence.
  assign sum = SUM_W'(sine_v[0]) + SUM_W'(sine_v[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_valid <= 1'b0;
      sample_data  <= '0;
    end else if (!sample_valid || sample_ready) begin
      sample_valid <= 1'b1;
      sample_data  <= sum;
    end
  end

endmodule

// File: rtl/tone_gen_checker.sv
module tone_gen_checker
  import tone_gen_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_valid,
  input logic                    sample_ready,
  input logic signed [SUM_W-1:0] sample_data,
  input logic                    load,
  input logic                    run_lo,
  input logic                    run_hi,
  input logic [RATIO_W-1:0]      ratio_lo,
  input logic [RATIO_W-1:0]      cnt_lo,
  input logic [STEP_W-1:0]       step_lo
);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !sample_ready |=> sample_valid && $stable(sample_data));

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> sample_valid);

  a_r8_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lo && !run_hi && sample_ready |=> sample_data == '0);

  a_r4_single_range: assert property (@(posedge clk) disable iff (!rst_n)
    !run_hi && sample_ready |=> (sample_data >= -127) && (sample_data <= 127));

  a_r6_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_lo == '0 && step_lo == '0);

  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    run_lo && !load && (cnt_lo == ratio_lo - RATIO_W'(1))
    |=> step_lo == STEP_W'($past(step_lo) + STEP_W'(1)));

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_lo |-> cnt_lo < ratio_lo);

endmodule

bind tone_gen_top tone_gen_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample_ready (sample_ready),
  .sample_data  (sample_data),
  .load         (load),
  .run_lo       (run_v[0]),
  .run_hi       (run_v[1]),
  .ratio_lo     (ratio_v[0]),
  .cnt_lo       (cnt_v[0]),
  .step_lo      (step_v[0])
);

// File: tb/tone_gen_top_bench.sv
module tone_gen_top_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [5:0]        cmd;
  logic              strobe;
  logic              ready;
  logic              valid;
  logic signed [8:0] data;

  int checks = 0;
  int errors = 0;

  tone_gen_top u_tone_gen_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .tone_cmd     (cmd),
    .cmd_strobe   (strobe),
    .sample_valid (valid),
    .sample_ready (ready),
    .sample_data  (data)
  );

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int sine_ref(int s);
    return rnd(127.0 * $sin(2.0 * 3.14159265358979 * s / 16.0));
  endfunction

  function automatic real low_hz(int i);
    case (i) 0: return 697.0; 1: return 770.0; 2: return 852.0; default: return 941.0; endcase
  endfunction

  function automatic real high_hz(int i);
    case (i) 0: return 1209.0; 1: return 1336.0; 2: return 1477.0; default: return 1633.0; endcase
  endfunction

  function automatic real modem_hz(int i);
    case (i)
      0: return 1070.0; 1: return 1270.0; 2: return 2025.0; 3: return 2225.0;
      4: return 1200.0; 5: return 2200.0; 6: return 980.0;  default: return 1180.0;
    endcase
  endfunction

  function automatic real note_hz(int n);
    return 440.0 * (2.0 ** (n / 12.0));
  endfunction

  function automatic int ratio_of(real f);
    return $rtoi(3579545.0 / (16.0 * f) + 0.5);
  endfunction

  // R1 / R2 decode, written from the requirement text
  task automatic decode(input logic [5:0] c, output int ra, output int rb,
                        output bit dual, output bit stby);
    ra = 1; rb = 1; dual = 0; stby = 0;
    case (c[5:4])
      2'b01: begin ra = ratio_of(low_hz(c[3:2])); rb = ratio_of(high_hz(c[1:0])); dual = 1; end
      2'b10: ra = ratio_of(modem_hz(c[2:0]));
      2'b11: ra = ratio_of(note_hz(c[3:0]));
      default: begin
        if (!c[3]) ra = c[2] ? ratio_of(high_hz(c[1:0])) : ratio_of(low_hz(c[1:0]));
        else if (c[2:0] == 3'd0) stby = 1;
        else ra = ratio_of(note_hz(c[2:0]));
      end
    endcase
  endtask

  function automatic int model(int k, int ra, int rb, bit dual, bit stby);
    int v;
    if (stby) return 0;
    v = sine_ref(((k - 1) / ra) % 16);
    if (dual) v += sine_ref(((k - 1) / rb) % 16);
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Load a command and compare every cycle for len cycles (R6 timing).
  task automatic run_tone(input logic [5:0] c, input int len, input int stall_pct,
                          input bit disturb, input string req);
    int ra, rb, expv, bad, fa, fe;
    bit dual, stby;
    decode(c, ra, rb, dual, stby);
    @(negedge clk); cmd = c; strobe = 1'b1; ready = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    ready = 1'b1;
    expv = model(1, ra, rb, dual, stby);
    bad = 0; fa = 0; fe = 0;
    for (int k = 2; k <= len + 1; k++) begin
      @(negedge clk);
      if (data !== 9'(expv) || valid !== 1'b1) begin
        if (bad == 0) begin fa = data; fe = expv; end
        bad++;
      end
      if (disturb && k == len / 2) begin
        cmd = ~c;
        strobe = 1'b1;
      end
      ready = ($urandom_range(99) >= stall_pct);
      if (ready) expv = model(k, ra, rb, dual, stby);
    end
    check(bad == 0, req, fa, fe);
    ready = 1'b1;
  endtask

  initial begin
    #(20ns * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] rc;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd = '0; strobe = 1'b0; ready = 1'b1;
    repeat (5) @(negedge clk);
    check(valid == 1'b0, "R8 valid in reset", valid, 0);
    check(data == 9'sd0, "R8 data in reset", data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(valid == 1'b1, "R9 valid after reset", valid, 1);
    check(data == 9'sd0, "R8 standby after reset", data, 0);

    run_tone(6'b000001, 4800, 0, 0, "R4 single low 770");
    run_tone(6'b000111, 2300, 0, 0, "R4 single high 1633");
    run_tone(6'b001000, 400, 0, 0, "R8 standby command");
    run_tone(6'b100010, 1800, 0, 0, "R2 modem 2025");
    run_tone(6'b101010, 1800, 0, 0, "R1 modem bit3 ignored");
    run_tone(6'b110000, 2200, 0, 0, "R2 musical 440");
    run_tone(6'b001011, 2200, 0, 0, "R1 musical in mixed family");
    run_tone(6'b000000, 700, 0, 0, "R6 first load");
    run_tone(6'b000000, 700, 0, 0, "R6 reload same command");
    for (int p = 0; p < 16; p++)
      run_tone(6'b010000 | 6'(p), 1300, 0, 0, "R3 dual pair");
    run_tone(6'b010110, 2400, 0, 1, "R7 bus and strobe rise ignored");
    run_tone(6'b011111, 3000, 60, 0, "R9 heavy stall");
    run_tone(6'b111111, 1600, 0, 0, "R5 top note sequence");
    for (int n = 0; n < 20; n++) begin
      rc = 6'($urandom_range(63));
      run_tone(rc, 2500, 10, 0, "R5 random command");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule